// File: doc/BRIEF.md
# Dual-Mode Serial Port Control and Status Register

This block is the single 8-bit control and status register of a serial port that can run either as a UART or as an SPI port. It sits on a simple CPU register bus with an address, a write enable, a read strobe and byte-wide data. It holds three configuration bits: port mode, receiver enable and SPI role. It also keeps four sticky status flags, which the serial engine sets through one-cycle event pulses. The register also shows a live busy bit.

The flags clear in different ways. The two error flags clear as a side effect of reading this register. The receive-ready flag clears when the data buffer is read, and writing zero to it drops the pending byte through a discard strobe sent toward the buffer. The transmit-done flag clears only when software writes zero to it. The shift engines, the baud generator and the data buffer itself are outside the block. The block sees only event strobes and the buffer-read strobe.

Top module: `sercsr_top`

## Requirements
- R1: After synchronous reset, all stored bits (7:1) are 0 and the configuration outputs are 0.
- R2: A write at the register address loads bit 7 (mode: 0 = SPI, 1 = UART), bit 6 (UART receiver enable) and bit 5 (SPI role: 0 = master, 1 = slave). These bits read back and drive `cfg_uart`, `cfg_rx_en` and `cfg_spi_slave` from the next cycle.
- R3: Bit 4 (framing error) and bit 3 (parity error) are set by their event pulses. Any read of the register returns their current values, and they read 0 from the cycle after that read.
- R4: Bit 2 (received byte ready) is set by `evt_rx_done`. It clears the cycle after a `dbuf_rd` pulse. A register read does not clear it.
- R5: Writing 0 to bit 2 clears it. While bit 2 is 1 and no receive event arrives in that cycle, the same write raises `dbuf_discard` in that cycle. When bit 2 is 0, no discard is raised.
- R6: Bit 1 (transmit done) is set by `evt_tx_done` and cleared only by writing 0 to bit 1.
- R7: Writing 1 to bits 4:1 leaves them unchanged. Writes to bit 0 have no effect.
- R8: If a flag's set event and its clear (by read, buffer read or write of zero) fall in the same cycle, the flag ends up set.
- R9: In UART mode with the receiver disabled (bit 6 = 0), framing-error, parity-error and receive events are ignored.
- R10: In SPI mode, error events are ignored. Receive events count only in slave role, and transmit events count only in master role.
- R11: Bit 0 reads `ssel_in` in SPI slave role. In every other mode it reads `engine_busy`.
- R12: `bus_rdata` shows the register byte while `bus_rd` is high at the register address and 0 otherwise. A read at another address clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Write enable |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| dbuf_rd | input | 1 | Data buffer was read this cycle |
| dbuf_discard | output | 1 | Drop the byte held in the data buffer |
| evt_frame_err | input | 1 | Received byte had a bad stop bit |
| evt_parity_err | input | 1 | Received byte failed parity |
| evt_rx_done | input | 1 | A byte was received |
| evt_tx_done | input | 1 | The last written byte was transmitted |
| engine_busy | input | 1 | Serial engine is shifting |
| ssel_in | input | 1 | SPI slave-select level |
| cfg_uart | output | 1 | Mode bit: 1 = UART |
| cfg_rx_en | output | 1 | UART receiver enable |
| cfg_spi_slave | output | 1 | SPI role: 1 = slave |

## Verification
The collision that matters most is a flag's set event landing in the same cycle as its clear. The bench provokes it in three ways: a receive event together with a data-buffer read, a framing-error event together with a register read, and a transmit event together with a write of zero. In each case the bench judges the outcome on the following reads. The read in the colliding cycle must still show the old value, and the next read must show the flag set. The discard strobe is also checked in the cycle of the write of zero, both with a byte pending and with none pending.

// File: rtl/sercsr_pkg.sv
package sercsr_pkg;

    localparam int DATA_W    = 8;
    localparam int NUM_FLAGS = 4;

    // flag slots; flag i sits at register bit i + FLAG_LSB
    localparam int FLG_TX   = 0;
    localparam int FLG_RX   = 1;
    localparam int FLG_PE   = 2;
    localparam int FLG_FE   = 3;
    localparam int FLAG_LSB = 1;
    localparam int CFG_LSB  = FLAG_LSB + NUM_FLAGS;

    typedef enum logic {
        MODE_SPI  = 1'b0,
        MODE_UART = 1'b1
    } port_mode_e;

    typedef struct packed {
        port_mode_e mode;
        logic       rx_en;
        logic       spi_slave;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    typedef logic [NUM_FLAGS-1:0] flag_vec_t;

    typedef struct packed {
        logic frame_err;
        logic parity_err;
        logic rx_done;
        logic tx_done;
    } evt_t;

    function automatic cfg_t cfg_from_byte(input logic [DATA_W-1:0] d);
        cfg_t c;
        c.mode      = port_mode_e'(d[CFG_LSB+2]);
        c.rx_en     = d[CFG_LSB+1];
        c.spi_slave = d[CFG_LSB];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] status_byte(input cfg_t c,
                                                      input flag_vec_t f,
                                                      input logic busy);
        return {c, f, busy};
    endfunction

    // keep only events that are meaningful in the current configuration
    function automatic flag_vec_t qualify_events(input cfg_t c, input evt_t e);
        flag_vec_t m;
        logic uart;
        logic rx_ok;
        logic err_ok;
        logic tx_ok;
        uart   = (c.mode == MODE_UART);
        rx_ok  = uart ? c.rx_en : c.spi_slave;
        err_ok = uart && c.rx_en;
        tx_ok  = uart || !c.spi_slave;
        m          = '0;
        m[FLG_TX]  = e.tx_done    && tx_ok;
        m[FLG_RX]  = e.rx_done    && rx_ok;
        m[FLG_PE]  = e.parity_err && err_ok;
        m[FLG_FE]  = e.frame_err  && err_ok;
        return m;
    endfunction

    function automatic logic live_busy(input cfg_t c, input logic eng_busy,
                                       input logic ssel);
        if (c.mode == MODE_SPI && c.spi_slave) return ssel;
        return eng_busy;
    endfunction

endpackage

// File: rtl/sercsr_decode.sv
module sercsr_decode #(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CSR_ADDR = 8'h40
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic              wr_hit,
    output logic              rd_hit
);
    logic sel;

    always_comb begin
        sel    = (bus_addr == CSR_ADDR);
        wr_hit = sel && bus_wr;
        rd_hit = sel && bus_rd;
    end

endmodule

// File: rtl/sercsr_cfg.sv
module sercsr_cfg
    import sercsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wdata,
    output cfg_t              cfg_q
);
    logic [CFG_W-1:0] cfg_bits;

    always_comb cfg_bits = wdata[CFG_LSB +: CFG_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_hit) begin
            cfg_q <= cfg_t'(cfg_bits);
        end
    end

    // R2
    cfg_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> cfg_q == cfg_from_byte($past(wdata)));

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_hit |=> $stable(cfg_q));

endmodule

// File: rtl/sercsr_flag.sv
module sercsr_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_o <= 1'b0;
        end else if (set_i) begin
            flag_o <= 1'b1;
        end else if (clr_i) begin
            flag_o <= 1'b0;
        end
    end

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_o);

    // R3
    clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !flag_o);

    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !set_i) |=> $stable(flag_o));

endmodule

// File: rtl/sercsr_top.sv
module sercsr_top
    import sercsr_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CSR_ADDR = 8'h40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              dbuf_rd,
    output logic              dbuf_discard,
    input  logic              evt_frame_err,
    input  logic              evt_parity_err,
    input  logic              evt_rx_done,
    input  logic              evt_tx_done,
    input  logic              engine_busy,
    input  logic              ssel_in,
    output logic              cfg_uart,
    output logic              cfg_rx_en,
    output logic              cfg_spi_slave
);
    logic      wr_hit;
    logic      rd_hit;
    cfg_t      cfg_q;
    evt_t      evt;
    flag_vec_t set_vec;
    flag_vec_t clr_vec;
    flag_vec_t wz_vec;
    flag_vec_t flags;
    logic      busy;

    sercsr_decode #(
        .ADDR_W   (ADDR_W),
        .CSR_ADDR (CSR_ADDR)
    ) decode_i (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .wr_hit   (wr_hit),
        .rd_hit   (rd_hit)
    );

    sercsr_cfg cfg_i (
        .clk    (clk),
        .rst    (rst),
        .wr_hit (wr_hit),
        .wdata  (bus_wdata),
        .cfg_q  (cfg_q)
    );

    always_comb begin
        evt.frame_err  = evt_frame_err;
        evt.parity_err = evt_parity_err;
        evt.rx_done    = evt_rx_done;
        evt.tx_done    = evt_tx_done;
        set_vec        = qualify_events(cfg_q, evt);
        // write-zero-to-clear: a 0 in a flag position clears, a 1 does nothing
        wz_vec         = wr_hit ? ~bus_wdata[FLAG_LSB +: NUM_FLAGS] : '0;
        clr_vec        = wz_vec;
        clr_vec[FLG_RX] = wz_vec[FLG_RX] | dbuf_rd;
        clr_vec[FLG_PE] = wz_vec[FLG_PE] | rd_hit;
        clr_vec[FLG_FE] = wz_vec[FLG_FE] | rd_hit;
    end

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        sercsr_flag flag_i (
            .clk    (clk),
            .rst    (rst),
            .set_i  (set_vec[g]),
            .clr_i  (clr_vec[g]),
            .flag_o (flags[g])
        );
    end

    always_comb begin
        busy          = live_busy(cfg_q, engine_busy, ssel_in);
        bus_rdata     = rd_hit ? status_byte(cfg_q, flags, busy) : '0;
        // a byte arriving in the same cycle is kept, so it is not dropped
        dbuf_discard  = wz_vec[FLG_RX] && flags[FLG_RX] && !set_vec[FLG_RX];
        cfg_uart      = (cfg_q.mode == MODE_UART);
        cfg_rx_en     = cfg_q.rx_en;
        cfg_spi_slave = cfg_q.spi_slave;
    end

    // R5
    discard_clears_chk: assert property (@(posedge clk) disable iff (rst)
        dbuf_discard |=> !flags[FLG_RX]);

    // R9
    rx_disabled_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_uart && !cfg_rx_en && !flags[FLG_RX] && !flags[FLG_FE]) |=>
            (!flags[FLG_RX] && !flags[FLG_FE]));

    // R10
    spi_no_error_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_uart && !flags[FLG_PE]) |=> !flags[FLG_PE]);

    // R4
    csr_read_keeps_rx_chk: assert property (@(posedge clk) disable iff (rst)
        (flags[FLG_RX] && !dbuf_rd && !wz_vec[FLG_RX]) |=> flags[FLG_RX]);

endmodule

// File: tb/sercsr_top_tb_top.sv
`timescale 1ns/1ps
module sercsr_top_tb_top;
    localparam logic [7:0] CSR   = 8'h40;
    localparam logic [7:0] OTHER = 8'h41;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] bus_addr;
    logic       bus_wr;
    logic       bus_rd;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       dbuf_rd;
    logic       dbuf_discard;
    logic       evt_frame_err;
    logic       evt_parity_err;
    logic       evt_rx_done;
    logic       evt_tx_done;
    logic       engine_busy;
    logic       ssel_in;
    logic       cfg_uart;
    logic       cfg_rx_en;
    logic       cfg_spi_slave;

    int compared   = 0;
    int mismatched = 0;
    bit done       = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    sercsr_top #(.ADDR_W(8), .CSR_ADDR(CSR)) dut_i (
        .clk            (clk),
        .rst            (rst),
        .bus_addr       (bus_addr),
        .bus_wr         (bus_wr),
        .bus_rd         (bus_rd),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .dbuf_rd        (dbuf_rd),
        .dbuf_discard   (dbuf_discard),
        .evt_frame_err  (evt_frame_err),
        .evt_parity_err (evt_parity_err),
        .evt_rx_done    (evt_rx_done),
        .evt_tx_done    (evt_tx_done),
        .engine_busy    (engine_busy),
        .ssel_in        (ssel_in),
        .cfg_uart       (cfg_uart),
        .cfg_rx_en      (cfg_rx_en),
        .cfg_spi_slave  (cfg_spi_slave)
    );

    // monitor: every register read is compared against the scoreboard
    always @(negedge clk) begin
        if (!rst && bus_rd && bus_addr == CSR) begin
            compared++;
            if (exp_q.size() == 0) begin
                mismatched++;
                $display("FAIL unexpected read: actual %02h expected none", bus_rdata);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    mismatched++;
                    $display("FAIL %s: actual %02h expected %02h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
        bus_wr = 0; bus_rd = 0; dbuf_rd = 0;
        evt_frame_err = 0; evt_parity_err = 0; evt_rx_done = 0; evt_tx_done = 0;
        bus_addr = CSR;
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic rd_csr(input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_addr = CSR; bus_rd = 1;
        step();
    endtask

    task automatic wr_csr(input logic [7:0] d);
        bus_addr = CSR; bus_wr = 1; bus_wdata = d;
        step();
    endtask

    task automatic events(input logic fe, input logic pe, input logic rx, input logic tx);
        evt_frame_err = fe; evt_parity_err = pe; evt_rx_done = rx; evt_tx_done = tx;
        step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        rst = 1; bus_addr = CSR; bus_wr = 0; bus_rd = 0; bus_wdata = 0; dbuf_rd = 0;
        evt_frame_err = 0; evt_parity_err = 0; evt_rx_done = 0; evt_tx_done = 0;
        engine_busy = 0; ssel_in = 0;
        repeat (4) @(posedge clk);
        #1 rst = 0;

        // R1 reset state
        rd_csr(8'h00, "R1 reset byte");
        chk("R1 cfg outputs", {5'b0, cfg_uart, cfg_rx_en, cfg_spi_slave}, 8'h00);

        // R2 configuration write
        wr_csr(8'hC0);
        rd_csr(8'hC0, "R2 config readback");
        chk("R2 cfg outputs", {5'b0, cfg_uart, cfg_rx_en, cfg_spi_slave}, 8'h06);

        // R3 error flags clear on read
        events(1, 1, 0, 0);
        rd_csr(8'hD8, "R3 errors visible");
        rd_csr(8'hC0, "R3 errors cleared by read");

        // R4 receive flag clears on buffer read only
        events(0, 0, 1, 0);
        rd_csr(8'hC4, "R4 rx ready");
        rd_csr(8'hC4, "R4 rx kept over csr read");
        dbuf_rd = 1; step();
        rd_csr(8'hC0, "R4 rx cleared by buffer read");

        // R6 / R7 transmit flag and write-one no effect
        events(0, 0, 0, 1);
        rd_csr(8'hC2, "R6 tx done set");
        events(1, 0, 1, 0);
        wr_csr(8'hDF);
        rd_csr(8'hD6, "R7 write ones keep flags");
        dbuf_rd = 1; step();
        wr_csr(8'hC0);
        rd_csr(8'hC0, "R6 tx cleared by write zero");

        // R5 discard strobe
        events(0, 0, 1, 0);
        bus_addr = CSR; bus_wr = 1; bus_wdata = 8'hC0;
        @(negedge clk);
        chk("R5 discard with byte pending", {7'b0, dbuf_discard}, 8'h01);
        step();
        rd_csr(8'hC0, "R5 rx cleared by write zero");
        bus_addr = CSR; bus_wr = 1; bus_wdata = 8'hC0;
        @(negedge clk);
        chk("R5 no discard when empty", {7'b0, dbuf_discard}, 8'h00);
        step();

        // R8 set wins over clear in the same cycle
        evt_rx_done = 1; dbuf_rd = 1; step();
        rd_csr(8'hC4, "R8 rx set beats buffer read");
        evt_frame_err = 1;
        rd_csr(8'hC4, "R8 read returns pre-event value");
        rd_csr(8'hD4, "R8 fe set beats csr read");
        rd_csr(8'hC4, "R8 fe then cleared");
        dbuf_rd = 1; step();
        evt_tx_done = 1;
        wr_csr(8'hC0);
        rd_csr(8'hC2, "R8 tx set beats write zero");
        bus_addr = CSR; bus_wr = 1; bus_wdata = 8'hC0;
        evt_rx_done = 1;
        @(negedge clk);
        chk("R8 no discard when byte arrives", {7'b0, dbuf_discard}, 8'h00);
        step();
        rd_csr(8'hC4, "R8 rx set beats write zero");
        dbuf_rd = 1; step();

        // R9 UART receiver disabled
        wr_csr(8'h80);
        events(1, 1, 1, 0);
        rd_csr(8'h80, "R9 events ignored with rx off");

        // R10 SPI role gating
        wr_csr(8'h00);
        events(1, 1, 1, 0);
        rd_csr(8'h00, "R10 master ignores rx and errors");
        events(0, 0, 0, 1);
        rd_csr(8'h02, "R10 master takes tx");
        wr_csr(8'h20);
        events(0, 0, 0, 1);
        rd_csr(8'h20, "R10 slave ignores tx");
        events(0, 0, 1, 0);
        rd_csr(8'h24, "R10 slave takes rx");
        dbuf_rd = 1; step();

        // R11 busy bit source
        ssel_in = 1; engine_busy = 0;
        rd_csr(8'h21, "R11 slave busy follows select");
        ssel_in = 0; engine_busy = 1;
        rd_csr(8'h20, "R11 slave ignores engine busy");
        wr_csr(8'hC0);
        rd_csr(8'hC1, "R11 uart busy follows engine");
        engine_busy = 0;
        wr_csr(8'hC1);
        rd_csr(8'hC0, "R7 bit0 write ignored");

        // R12 read at another address
        events(1, 0, 0, 0);
        bus_addr = OTHER; bus_rd = 1;
        @(negedge clk);
        chk("R12 foreign read data", bus_rdata, 8'h00);
        step();
        rd_csr(8'hD0, "R12 foreign read clears nothing");
        rd_csr(8'hC0, "R12 then cleared");

        step();
        if (exp_q.size() != 0) begin
            mismatched++;
            $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule